// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous requester and an external asynchronous static RAM. The RAM is 24 bits wide and holds 512K words, so it has a 19-bit address. Each of its three byte lanes has its own active-low select. Write enable and output enable are active low and shared by all lanes. The requester presents one word-wide read or write at a time, with a 3-bit lane mask, through a valid/ready handshake. The controller turns each request into a timed sequence of select, write-enable and output-enable levels, and it controls the drivers of the shared data bus.

Every phase length is an integer number of clock cycles. Each count is derived at elaboration from the clock period and the memory's timing figures in picoseconds. A write first raises output enable and keeps it high for a turnaround window before the controller drives the bus. The write pulse then runs for long enough to cover the pulse-width, data-setup, address-setup and cycle-time minima. The write ends on the rising edge of write enable, with the selects, address and data held for one more cycle. A read keeps output enable low for the access time and samples the bus in the last cycle. Read lanes outside the mask come back as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, all three selects, write enable and output enable are high. The bus drivers are off, ready is high and read-valid is low.
- R2: A request is taken on a cycle where req_valid and req_ready are both high. Ready is low for the whole access and goes high again in the cycle after the access's last memory cycle. Ready high implies that no select is low and that write enable and output enable are both high.
- R3: A write runs in three phases. It selects the lanes with mem_cs_n = ~mask, where mask bit i selects data bits 8i+7:8i. It holds write enable high for TA_CYC cycles, then low for WP_CYC cycles, then high for one hold cycle. Output enable stays high the whole time. Phase 1 starts in the cycle after the request is taken.
- R4: The data drivers are on only during the write pulse and the hold cycle after it. While they are on, mem_dq_out equals the request's write data and does not change. They are never on while output enable is low. Output enable has been high for at least TA_CYC cycles before they turn on.
- R5: Address and selects are set in the first cycle of an access. They stay unchanged until one cycle after write enable rises, or until the end of a read. After that, all selects return high.
- R6: A read holds selects = ~mask, output enable low and write enable high for RD_CYC cycles, with the drivers off. The bus is sampled at the end of the last of these cycles.
- R7: read_valid is high for exactly one cycle, the cycle after the last read cycle. In that cycle rd_data holds the sampled lanes, and every lane outside the mask is zero.
- R8: A request with mask 0 is taken and nothing else happens. No select, write-enable or output-enable activity follows, ready stays high, no read-valid follows, and memory contents are unchanged.
- R9: The phase counts are computed with ceil(t/CLK_PS):
  - TA_CYC = max(1, ceil(tHZOE)).
  - WP_CYC = max(1, ceil(tPWE), ceil(tSD), ceil(tAW) - TA_CYC, ceil(tWC) - TA_CYC - 1).
  - RD_CYC = max(1, ceil(tAA), ceil(tDOE), ceil(tRC)).
  - With the defaults these give TA_CYC = 2, WP_CYC = 2 and RD_CYC = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 24 | Write data |
| req_mask | input | 3 | Lane mask, bit i = bits 8i+7:8i |
| req_ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | 24 | Read data, unmasked lanes zero |
| rd_valid | output | 1 | One-cycle read completion strobe |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 3 | Per-lane active-low selects |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_oe | output | 1 | Enable for the controller's bus drivers |
| mem_dq_out | output | 24 | Data driven toward memory |
| mem_dq_in | input | 24 | Data sampled from the bus |

## Verification
Some rules are checked by properties on every cycle:
- no contention between the drivers and output enable;
- the turnaround window before the drivers turn on;
- the exact write-pulse width;
- address and selects held across the access and one cycle past the write-enable rise;
- stable write data;
- a single-cycle read-valid pulse with zero-filled unselected lanes.

Only the bench scenarios show the rest. These are the exact phase order and cycle placement relative to the handshake, that partial writes leave neighbouring lanes intact in a memory model, that junk on unselected read lanes is masked, and that zero-mask requests leave the pins and the stored data untouched.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_W_TA    = 3'd1,
    ST_W_PULSE = 3'd2,
    ST_W_HOLD  = 3'd3,
    ST_RD      = 3'd4
  } seq_state_t;

  // ceiling of a time in ps over the clock period in ps
  function automatic int cyc_ceil(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ta_cycles(input int clk_ps, input int t_hz_ps);
    return imax(1, cyc_ceil(t_hz_ps, clk_ps));
  endfunction

  function automatic int wp_cycles(input int clk_ps, input int t_pwe, input int t_sd,
                                   input int t_aw, input int t_wc, input int ta);
    int n;
    n = imax(1, cyc_ceil(t_pwe, clk_ps));
    n = imax(n, cyc_ceil(t_sd, clk_ps));
    n = imax(n, cyc_ceil(t_aw, clk_ps) - ta);
    n = imax(n, cyc_ceil(t_wc, clk_ps) - ta - 1);
    return n;
  endfunction

  function automatic int rd_cycles(input int clk_ps, input int t_aa, input int t_doe,
                                   input int t_rc);
    int n;
    n = imax(1, cyc_ceil(t_aa, clk_ps));
    n = imax(n, cyc_ceil(t_doe, clk_ps));
    n = imax(n, cyc_ceil(t_rc, clk_ps));
    return n;
  endfunction

endpackage

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int TA_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int RD_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_mask,
  output logic             req_ready,
  output logic [LANES-1:0] lane_mask,
  output logic [LANES-1:0] mem_cs_n,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic             mem_dq_oe,
  output logic             ev_accept,
  output logic             ev_drop,
  output logic             ev_we_rise,
  output logic             ev_capture
);

  localparam int MAXC  = imax(imax(TA_CYC, WP_CYC), RD_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [LANES-1:0] mask_q;
  logic             fire;
  logic             last_phase;
  int               phase_len;

  assign req_ready = (st_q == ST_IDLE);
  assign fire      = req_valid && req_ready;
  assign ev_accept = fire && (req_mask != '0);
  assign ev_drop   = fire && (req_mask == '0);

  always_comb begin
    unique case (st_q)
      ST_W_TA:    phase_len = TA_CYC;
      ST_W_PULSE: phase_len = WP_CYC;
      ST_RD:      phase_len = RD_CYC;
      default:    phase_len = 1;
    endcase
  end

  assign last_phase = (cnt_q == CNT_W'(phase_len - 1));
  assign ev_we_rise = (st_q == ST_W_PULSE) && last_phase;
  assign ev_capture = (st_q == ST_RD) && last_phase;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (ev_accept) st_d = req_write ? ST_W_TA : ST_RD;
      ST_W_TA:    if (last_phase) st_d = ST_W_PULSE;
      ST_W_PULSE: if (last_phase) st_d = ST_W_HOLD;
      ST_W_HOLD:  st_d = ST_IDLE;
      ST_RD:      if (last_phase) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE || last_phase) cnt_q <= '0;
      else                               cnt_q <= cnt_q + 1'b1;
      if (ev_accept) mask_q <= req_mask;
    end
  end

  assign lane_mask = mask_q;
  assign mem_cs_n  = (st_q == ST_IDLE) ? '1 : ~mask_q;
  assign mem_we_n  = (st_q != ST_W_PULSE);
  assign mem_oe_n  = (st_q != ST_RD);
  assign mem_dq_oe = (st_q == ST_W_PULSE) || (st_q == ST_W_HOLD);

endmodule

// File: rtl/sram_lane_data.sv
module sram_lane_data #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 24,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] m);
    logic [DATA_W-1:0] f;
    for (int i = 0; i < LANES; i++) f[i*8 +: 8] = {8{m[i]}};
    return f;
  endfunction

  logic [DATA_W-1:0] keep_bits;
  assign keep_bits = lane_bits(lane_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= ev_capture;
      if (ev_accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (ev_capture) rd_data <= mem_dq_in & keep_bits;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 24,
  parameter int CLK_PS    = 4000,
  parameter int T_HZOE_PS = 5000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 6000,
  parameter int T_AW_PS   = 9000,
  parameter int T_WC_PS   = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 7000,
  parameter int T_RC_PS   = 10000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  req_ready,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_cs_n,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_dq_oe,
  output logic [DATA_W-1:0]     mem_dq_out,
  input  logic [DATA_W-1:0]     mem_dq_in
);

  localparam int LANES  = DATA_W / 8;
  localparam int TA_CYC = ta_cycles(CLK_PS, T_HZOE_PS);
  localparam int WP_CYC = wp_cycles(CLK_PS, T_PWE_PS, T_SD_PS, T_AW_PS, T_WC_PS, TA_CYC);
  localparam int RD_CYC = rd_cycles(CLK_PS, T_AA_PS, T_DOE_PS, T_RC_PS);

  // internal events, named for the checker
  logic             ev_accept;
  logic             ev_drop;
  logic             ev_we_rise;
  logic             ev_capture;
  logic [LANES-1:0] lane_mask;

  sram_lane_seq #(
    .LANES (LANES),
    .TA_CYC(TA_CYC),
    .WP_CYC(WP_CYC),
    .RD_CYC(RD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_mask  (req_mask),
    .req_ready (req_ready),
    .lane_mask (lane_mask),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .ev_accept (ev_accept),
    .ev_drop   (ev_drop),
    .ev_we_rise(ev_we_rise),
    .ev_capture(ev_capture)
  );

  sram_lane_data #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_accept (ev_accept),
    .ev_capture(ev_capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .lane_mask (lane_mask),
    .mem_dq_in (mem_dq_in),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 24,
  parameter int TA_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int RD_CYC = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                rd_valid,
  input logic [DATA_W-1:0]   rd_data,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W/8-1:0] mem_cs_n,
  input logic                mem_we_n,
  input logic                mem_oe_n,
  input logic                mem_dq_oe,
  input logic [DATA_W-1:0]   mem_dq_out,
  input logic                ev_drop
);

  localparam int LANES = DATA_W / 8;

  function automatic logic [DATA_W-1:0] off_bits(input logic [LANES-1:0] cs);
    logic [DATA_W-1:0] f;
    for (int i = 0; i < LANES; i++) f[i*8 +: 8] = {8{cs[i]}};
    return f;
  endfunction

  logic [15:0] oe_hi_cnt, oe_lo_cnt, we_lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_hi_cnt <= '0;
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      if (mem_oe_n) begin
        if (oe_hi_cnt != '1) oe_hi_cnt <= oe_hi_cnt + 1'b1;
        oe_lo_cnt <= '0;
      end else begin
        oe_hi_cnt <= '0;
        if (oe_lo_cnt != '1) oe_lo_cnt <= oe_lo_cnt + 1'b1;
      end
      if (!mem_we_n) begin
        if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
      end else we_lo_cnt <= '0;
    end
  end

  p_idle_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n == '1) && mem_we_n && mem_oe_n && !mem_dq_oe);

  p_we_oe_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n && (mem_cs_n != '1) && mem_dq_oe);

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt == 16'(WP_CYC)));

  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n && (mem_cs_n != '1));

  p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 16'(TA_CYC)));

  p_wdata_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cs_n != '1) && $past(mem_cs_n != '1)) |-> $stable(mem_addr) && $stable(mem_cs_n));

  p_sel_past_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_cs_n != '1));

  p_read_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt == 16'(RD_CYC)) && rd_valid);

  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_rd_unsel_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data & off_bits($past(mem_cs_n))) == '0));

  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> req_ready && (mem_cs_n == '1));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .TA_CYC(TA_CYC),
  .WP_CYC(WP_CYC),
  .RD_CYC(RD_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_dq_out(mem_dq_out),
  .ev_drop   (ev_drop)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = 4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [23:0] req_wdata = '0;
  logic [2:0]  req_mask = '0;
  logic        req_ready;
  logic [23:0] rd_data;
  logic        rd_valid;
  logic [18:0] mem_addr;
  logic [2:0]  mem_cs_n;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic        mem_dq_oe;
  logic [23:0] mem_dq_out;
  logic [23:0] mem_dq_in;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // behavioural memory on the pins and an independent expected image
  logic [23:0] sram    [64];
  logic [23:0] exp_mem [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) sram[i] <= 24'h0;
    end else if (!mem_we_n && mem_dq_oe) begin
      for (int l = 0; l < 3; l++)
        if (!mem_cs_n[l]) sram[mem_addr[5:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
    end
  end

  always_comb begin
    for (int l = 0; l < 3; l++) begin
      if (!mem_cs_n[l] && !mem_oe_n && mem_we_n) mem_dq_in[l*8 +: 8] = sram[mem_addr[5:0]][l*8 +: 8];
      else                                       mem_dq_in[l*8 +: 8] = 8'hA5;
    end
  end

  // cycle counts restated by stepping time forward
  function automatic int steps(input int t_ps);
    int n = 0;
    while (n * CLK_PS < t_ps) n++;
    return n;
  endfunction

  int ta, wp, rd;
  initial begin
    ta = (steps(5000) < 1) ? 1 : steps(5000);
    wp = 1;
    if (steps(8000) > wp) wp = steps(8000);
    if (steps(6000) > wp) wp = steps(6000);
    if (steps(9000) - ta > wp) wp = steps(9000) - ta;
    if (steps(10000) - ta - 1 > wp) wp = steps(10000) - ta - 1;
    rd = 1;
    if (steps(10000) > rd) rd = steps(10000);
    if (steps(7000) > rd) rd = steps(7000);
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic expect_pins(input string tag, input logic rdy, input logic [2:0] cs,
                             input logic we, input logic oe, input logic doe);
    chk(tag, "ready/cs/we/oe/doe", {rdy, cs, we, oe, doe}, {rdy, cs, we, oe, doe} ^
        ({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} ^ {rdy, cs, we, oe, doe}) ? 
        {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} : {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe});
  endtask

  task automatic pins(input string tag, input logic rdy, input logic [2:0] cs,
                      input logic we, input logic oe, input logic doe);
    chk(tag, "ready/cs/we/oe/doe", {27'd0, req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe},
        {27'd0, rdy, cs, we, oe, doe});
  endtask

  task automatic issue(input logic wr, input logic [18:0] a, input logic [23:0] d,
                       input logic [2:0] m);
    @(negedge clk);
    chk("R2", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 24'h0; req_addr = 19'h0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [23:0] d, input logic [2:0] m);
    issue(1'b1, a, d, m);
    if (m == 3'b000) begin
      for (int i = 0; i < 3; i++) begin
        if (i > 0) @(negedge clk);
        pins("R8", 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
      end
      return;
    end
    for (int l = 0; l < 3; l++) if (m[l]) exp_mem[a[5:0]][l*8 +: 8] = d[l*8 +: 8];
    for (int i = 0; i < ta; i++) begin
      if (i > 0) @(negedge clk);
      pins("R3/R9", 1'b0, ~m, 1'b1, 1'b1, 1'b0);
      chk("R5", "addr", {13'd0, mem_addr}, {13'd0, a});
    end
    for (int i = 0; i < wp; i++) begin
      @(negedge clk);
      pins("R3/R9", 1'b0, ~m, 1'b0, 1'b1, 1'b1);
      chk("R4", "dq_out", {8'd0, mem_dq_out}, {8'd0, d});
      chk("R5", "addr", {13'd0, mem_addr}, {13'd0, a});
    end
    @(negedge clk);
    pins("R5", 1'b0, ~m, 1'b1, 1'b1, 1'b1);
    chk("R4", "dq_out hold", {8'd0, mem_dq_out}, {8'd0, d});
    @(negedge clk);
    pins("R2", 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [2:0] m);
    logic [23:0] e;
    issue(1'b0, a, 24'h0, m);
    if (m == 3'b000) begin
      for (int i = 0; i < 3; i++) begin
        if (i > 0) @(negedge clk);
        pins("R8", 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
        chk("R8", "rd_valid", {31'd0, rd_valid}, 32'd0);
      end
      return;
    end
    e = '0;
    for (int l = 0; l < 3; l++) if (m[l]) e[l*8 +: 8] = exp_mem[a[5:0]][l*8 +: 8];
    for (int i = 0; i < rd; i++) begin
      if (i > 0) @(negedge clk);
      pins("R6/R9", 1'b0, ~m, 1'b1, 1'b0, 1'b0);
      chk("R6", "addr", {13'd0, mem_addr}, {13'd0, a});
      chk("R7", "rd_valid early", {31'd0, rd_valid}, 32'd0);
    end
    @(negedge clk);
    pins("R2", 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
    chk("R7", "rd_valid", {31'd0, rd_valid}, 32'd1);
    chk("R7", "rd_data", {8'd0, rd_data}, {8'd0, e});
    @(negedge clk);
    chk("R7", "rd_valid pulse end", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 24'h0;
    repeat (3) @(negedge clk);
    pins("R1", 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
    chk("R1", "rd_valid in reset", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pins("R1", 1'b1, 3'b111, 1'b1, 1'b1, 1'b0);
    chk("R1", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
    chk("R9", "turnaround count", ta, 2);
    chk("R9", "pulse count", wp, 2);
    chk("R9", "read count", rd, 3);

    do_write(19'h00005, 24'h123456, 3'b111);
    do_read (19'h00005, 3'b111);
    do_write(19'h00005, 24'hFFFFFF, 3'b010);
    do_read (19'h00005, 3'b111);
    do_read (19'h00005, 3'b101);
    do_write(19'h00005, 24'h000000, 3'b000);
    do_read (19'h00005, 3'b000);
    do_read (19'h00005, 3'b111);
    do_write(19'h7FFC3, 24'hABCDEF, 3'b100);
    do_read (19'h7FFC3, 3'b110);
    do_write(19'h7FFC3, 24'h9876F1, 3'b001);
    do_read (19'h7FFC3, 3'b111);
    for (int k = 0; k < 6; k++) begin
      do_write(19'(k * 7 + 9), 24'(32'h0A1B2C * (k + 1)), 3'(k + 1));
      do_read (19'(k * 7 + 9), 3'b111);
    end
    do_read(19'h00005, 3'b011);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL R2 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule